// File: doc/BRIEF.md
# Chained DMA Event Prioritizer

This block keeps per-channel records of chained DMA events and decides which channel is submitted next to a transfer controller. A chaining completion report marks the channel as chained. Such reports arrive either from the controller's completion interface or from an internal early-completion path. A chained channel then goes ahead of every ordinary pending event, even when that channel's event-enable bit is clear. Its mark is removed once its submission is accepted.

A chaining report for a channel that is already marked cannot be queued a second time. It is recorded in a sticky missed-event vector, which software clears by writing ones. The chosen channel is offered through a registered valid/ready handshake. The chained and missed vectors are exposed for read-back. Software has no way to write the chained vector.

Top module: `chain_evt_prio`

## Requirements
- R1: While `rst` is high at a clock edge, `chain_flags`, `miss_flags` and `sel_valid` are all zero after that edge.
- R2: A cycle with `cmp_valid`=1 and `cmp_chain`=1 sets bit `cmp_chan` of `chain_flags` at the next edge. With `cmp_chain`=0 the report changes no flag.
- R3: A cycle with `early_valid`=1 sets bit `early_chan` of `chain_flags` at the next edge. Every early report counts as a chaining report.
- R4: A channel whose chained bit is set is offered ahead of all ordinary events, whatever its `evt_en` bit. The offer carries `sel_chained`=1.
- R5: When a new offer is formed, the lowest-numbered set chained bit wins. An ordinary event (bit set in both `evt_pend` and `evt_en`, lowest number first, `sel_chained`=0) is offered only when no chained bit is a candidate. With no candidate, `sel_valid` is 0.
- R6: A chained bit is cleared only at an edge where its channel is offered with `sel_chained`=1 and `sel_valid` and `sel_ready` are both high.
- R7: A chaining report for a channel whose chained bit is set and is not being cleared sets that channel's bit in `miss_flags`.
- R8: If a channel's chained bit is cleared by acceptance in the same cycle that a new chaining report arrives for it, the bit stays set and no miss is recorded.
- R9: If the completion interface and the early path report the same channel in one cycle, its chained bit is set and its missed bit is set.
- R10: Missed bits are sticky. A one in `miss_clr` clears the matching bit at the next edge, but a miss recorded in that same cycle wins.
- R11: While `sel_valid`=1 and `sel_ready`=0, `sel_valid`, `sel_chan` and `sel_chained` keep their values at the next edge.
- R12: A new offer is formed at an edge where `sel_valid` is 0 or `sel_ready` is 1. It reflects the flag vector held before that edge, with the bit being accepted left out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | 1 | Completion report from the transfer controller |
| cmp_chan | input | CW | Channel of the completion report |
| cmp_chain | input | 1 | Completion report carries the chaining code |
| early_valid | input | 1 | Internal early-completion chaining report |
| early_chan | input | CW | Channel of the early report |
| evt_pend | input | NCH | Ordinary pending events |
| evt_en | input | NCH | Event enables |
| miss_clr | input | NCH | Write-one-to-clear strobes for missed bits |
| sel_ready | input | 1 | Controller accepts the offered channel |
| sel_valid | output | 1 | A channel is offered |
| sel_chan | output | CW | Offered channel |
| sel_chained | output | 1 | The offer comes from a chained bit |
| chain_flags | output | NCH | Chained-event bits |
| miss_flags | output | NCH | Missed-event bits |

## Verification
Each report or clear strobe shows up in `chain_flags` and `miss_flags` one edge after the cycle that carries it. A report reaches the offer two edges later, since the offer register loads from the flag register. The bench drives inputs on the falling edge and updates its model for the coming rising edge. It compares every output at the following falling edge, so each result is sampled exactly in the cycle it is due. Directed sequences step through the same-cycle clear-and-set, the dual-path report and the held-offer cases. Seeded random traffic covers everything else.

// File: rtl/cep_pkg.sv
package cep_pkg;
  typedef enum logic {SRC_NORMAL = 1'b0, SRC_CHAIN = 1'b1} sel_src_e;
endpackage

// File: rtl/cep_pick.sv
module cep_pick #(
  parameter int N = 32,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  output logic         found,
  output logic [W-1:0] idx
);
  // scanning downward leaves the lowest set index as the result
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end
endmodule

// File: rtl/cep_flags.sv
module cep_flags #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] cmp_hit,
  input  logic [N-1:0] early_hit,
  input  logic [N-1:0] take_hit,
  input  logic [N-1:0] miss_clr,
  output logic [N-1:0] chain_q,
  output logic [N-1:0] miss_q
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic arrive;
    logic busy;
    assign arrive = cmp_hit[g] | early_hit[g];
    assign busy   = chain_q[g] & ~take_hit[g];
    always_ff @(posedge clk) begin
      if (rst) begin
        chain_q[g] <= 1'b0;
        miss_q[g]  <= 1'b0;
      end else begin
        chain_q[g] <= busy | arrive;
        miss_q[g]  <= (miss_q[g] & ~miss_clr[g])
                    | (cmp_hit[g] & early_hit[g])
                    | (arrive & busy);
      end
    end
  end
endmodule

// File: rtl/cep_sel.sv
module cep_sel #(
  parameter int N = 32,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] chain_cand,
  input  logic [N-1:0] norm_cand,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] chan,
  output cep_pkg::sel_src_e src
);
  import cep_pkg::*;
  logic         c_found, n_found;
  logic [W-1:0] c_idx, n_idx;
  logic         load;

  cep_pick #(.N(N)) u_pick_c (.req(chain_cand), .found(c_found), .idx(c_idx));
  cep_pick #(.N(N)) u_pick_n (.req(norm_cand),  .found(n_found), .idx(n_idx));

  assign load = ~valid | ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      chan  <= '0;
      src   <= SRC_NORMAL;
    end else if (load) begin
      valid <= c_found | n_found;
      chan  <= c_found ? c_idx : n_idx;
      src   <= c_found ? SRC_CHAIN : SRC_NORMAL;
    end
  end
endmodule

// File: rtl/chain_evt_prio.sv
module chain_evt_prio #(
  parameter int NCH = 32,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmp_valid,
  input  logic [CW-1:0]  cmp_chan,
  input  logic           cmp_chain,
  input  logic           early_valid,
  input  logic [CW-1:0]  early_chan,
  input  logic [NCH-1:0] evt_pend,
  input  logic [NCH-1:0] evt_en,
  input  logic [NCH-1:0] miss_clr,
  input  logic           sel_ready,
  output logic           sel_valid,
  output logic [CW-1:0]  sel_chan,
  output logic           sel_chained,
  output logic [NCH-1:0] chain_flags,
  output logic [NCH-1:0] miss_flags
);
  import cep_pkg::*;
  logic [NCH-1:0] cmp_hit, early_hit, take_hit;
  sel_src_e       src;

  assign cmp_hit   = (cmp_valid & cmp_chain) ? (NCH'(1) << cmp_chan) : '0;
  assign early_hit = early_valid ? (NCH'(1) << early_chan) : '0;
  assign take_hit  = (sel_valid & sel_ready & (src == SRC_CHAIN))
                     ? (NCH'(1) << sel_chan) : '0;

  cep_flags #(.N(NCH)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .cmp_hit  (cmp_hit),
    .early_hit(early_hit),
    .take_hit (take_hit),
    .miss_clr (miss_clr),
    .chain_q  (chain_flags),
    .miss_q   (miss_flags)
  );

  cep_sel #(.N(NCH)) u_sel (
    .clk       (clk),
    .rst       (rst),
    .chain_cand(chain_flags & ~take_hit),
    .norm_cand (evt_pend & evt_en),
    .ready     (sel_ready),
    .valid     (sel_valid),
    .chan      (sel_chan),
    .src       (src)
  );

  assign sel_chained = (src == SRC_CHAIN);
endmodule

// File: rtl/cep_chk.sv
module cep_chk #(
  parameter int NCH = 32,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic           clk,
  input logic           rst,
  input logic           cmp_valid,
  input logic [CW-1:0]  cmp_chan,
  input logic           cmp_chain,
  input logic           early_valid,
  input logic [CW-1:0]  early_chan,
  input logic [NCH-1:0] miss_clr,
  input logic           sel_ready,
  input logic           sel_valid,
  input logic [CW-1:0]  sel_chan,
  input logic           sel_chained,
  input logic [NCH-1:0] chain_flags,
  input logic [NCH-1:0] miss_flags
);
  logic [NCH-1:0] rep_mask, acc_mask;
  assign rep_mask = ((cmp_valid & cmp_chain) ? (NCH'(1) << cmp_chan) : '0)
                  | (early_valid ? (NCH'(1) << early_chan) : '0);
  assign acc_mask = (sel_valid & sel_ready & sel_chained) ? (NCH'(1) << sel_chan) : '0;

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (chain_flags == '0 && miss_flags == '0 && !sel_valid));

  // R11
  offer_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_valid && !sel_ready) |=> (sel_valid && $stable(sel_chan) && $stable(sel_chained)));

  // R2
  chain_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((chain_flags & ~$past(chain_flags) & ~$past(rep_mask)) == '0));

  // R6
  chain_fall_src_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((~chain_flags & $past(chain_flags) & ~$past(acc_mask)) == '0));

  // R10
  miss_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((~miss_flags & $past(miss_flags) & ~$past(miss_clr)) == '0));

  // R4
  chained_offer_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_valid && sel_chained) |-> chain_flags[sel_chan]);
endmodule

bind chain_evt_prio cep_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .cmp_chan(cmp_chan),
  .cmp_chain(cmp_chain), .early_valid(early_valid), .early_chan(early_chan),
  .miss_clr(miss_clr), .sel_ready(sel_ready), .sel_valid(sel_valid),
  .sel_chan(sel_chan), .sel_chained(sel_chained), .chain_flags(chain_flags),
  .miss_flags(miss_flags)
);

// File: tb/sim_chain_evt_prio.sv
module sim_chain_evt_prio;
  localparam int NCH = 32;
  localparam int CW  = 5;

  logic           clk = 1'b0;
  logic           rst;
  logic           cmp_valid, cmp_chain, early_valid, sel_ready;
  logic [CW-1:0]  cmp_chan, early_chan;
  logic [NCH-1:0] evt_pend, evt_en, miss_clr;
  logic           sel_valid, sel_chained;
  logic [CW-1:0]  sel_chan;
  logic [NCH-1:0] chain_flags, miss_flags;

  int checks = 0;
  int errors = 0;

  logic [NCH-1:0] m_chain, m_miss;
  logic           m_sv, m_sk;
  logic [CW-1:0]  m_sc;

  always #4 clk = ~clk;

  chain_evt_prio #(.NCH(NCH)) u0 (
    .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .cmp_chan(cmp_chan),
    .cmp_chain(cmp_chain), .early_valid(early_valid), .early_chan(early_chan),
    .evt_pend(evt_pend), .evt_en(evt_en), .miss_clr(miss_clr),
    .sel_ready(sel_ready), .sel_valid(sel_valid), .sel_chan(sel_chan),
    .sel_chained(sel_chained), .chain_flags(chain_flags), .miss_flags(miss_flags)
  );

  function automatic int lowest(logic [NCH-1:0] v);
    for (int i = 0; i < NCH; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_in();
    cmp_valid = 0; cmp_chain = 0; cmp_chan = '0;
    early_valid = 0; early_chan = '0; miss_clr = '0; sel_ready = 0;
  endtask

  // model of the coming edge, then compare after it
  task automatic tick();
    logic [NCH-1:0] rep_c, rep_e, clr, cand;
    int c, n;
    rep_c = (cmp_valid && cmp_chain) ? (NCH'(1) << cmp_chan) : '0;
    rep_e = early_valid ? (NCH'(1) << early_chan) : '0;
    clr   = (m_sv && sel_ready && m_sk) ? (NCH'(1) << m_sc) : '0;
    if (rst) begin
      m_chain = '0; m_miss = '0; m_sv = 0; m_sk = 0; m_sc = '0;
    end else begin
      cand = m_chain & ~clr;
      if (!m_sv || sel_ready) begin
        c = lowest(cand);
        n = lowest(evt_pend & evt_en);
        if (c >= 0) begin m_sv = 1; m_sc = CW'(c); m_sk = 1; end
        else if (n >= 0) begin m_sv = 1; m_sc = CW'(n); m_sk = 0; end
        else begin m_sv = 0; m_sk = 0; end
      end
      m_miss  = (m_miss & ~miss_clr) | (rep_c & rep_e) | ((rep_c | rep_e) & cand);
      m_chain = cand | rep_c | rep_e;
    end
    @(posedge clk);
    @(negedge clk);
    chk(chain_flags == m_chain, "R2/R3/R6 chain_flags", 64'(chain_flags), 64'(m_chain));
    chk(miss_flags == m_miss, "R7/R10 miss_flags", 64'(miss_flags), 64'(m_miss));
    chk(sel_valid == m_sv, "R5 sel_valid", 64'(sel_valid), 64'(m_sv));
    if (m_sv) begin
      chk(sel_chan == m_sc, "R5 sel_chan", 64'(sel_chan), 64'(m_sc));
      chk(sel_chained == m_sk, "R4 sel_chained", 64'(sel_chained), 64'(m_sk));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7531));
    rst = 1; idle_in(); evt_pend = '0; evt_en = '0;
    @(negedge clk);
    tick(); tick();
    // R1
    chk(chain_flags == '0 && miss_flags == '0 && !sel_valid, "R1 reset",
        {sel_valid, 31'd0, chain_flags}, 64'd0);
    rst = 0;
    tick();

    // R2, R4: chain on ch7 with enable clear; ordinary event on ch3
    evt_pend = NCH'(1) << 3; evt_en = NCH'(1) << 3;
    tick();
    chk(sel_chan == 3 && !sel_chained, "R5 ordinary only", 64'(sel_chan), 64'd3);
    cmp_valid = 1; cmp_chain = 1; cmp_chan = 7; sel_ready = 0;
    tick();
    chk(chain_flags == (NCH'(1) << 7), "R2 set ch7", 64'(chain_flags), 64'h80);
    idle_in(); sel_ready = 1;
    tick();
    chk(sel_valid && sel_chan == 7 && sel_chained, "R4 chained first", 64'(sel_chan), 64'd7);
    // R11: hold, R7: second report while set
    sel_ready = 0; cmp_valid = 1; cmp_chain = 1; cmp_chan = 7;
    tick();
    chk(miss_flags[7], "R7 miss ch7", 64'(miss_flags), 64'h80);
    chk(sel_chan == 7 && sel_chained, "R11 hold", 64'(sel_chan), 64'd7);
    idle_in();
    tick();
    // R6: accept clears, next offer is ordinary ch3
    sel_ready = 1;
    tick();
    chk(chain_flags == '0, "R6 cleared", 64'(chain_flags), 64'd0);
    chk(sel_chan == 3 && !sel_chained, "R12 masked accepted", 64'(sel_chan), 64'd3);
    // R2: report without chaining flag does nothing
    cmp_valid = 1; cmp_chain = 0; cmp_chan = 9;
    tick();
    chk(chain_flags == '0, "R2 no chain code", 64'(chain_flags), 64'd0);

    // R3, R5: early ch9, completion ch2
    idle_in(); cmp_valid = 1; cmp_chain = 1; cmp_chan = 9;
    early_valid = 1; early_chan = 2; sel_ready = 1;
    tick();
    chk(chain_flags == ((NCH'(1) << 9) | (NCH'(1) << 2)), "R3 early set",
        64'(chain_flags), 64'h204);
    idle_in(); sel_ready = 1;
    tick();
    chk(sel_chan == 2 && sel_chained, "R5 lowest chained", 64'(sel_chan), 64'd2);
    // R8: accept ch2 while a new report for ch2 arrives
    cmp_valid = 1; cmp_chain = 1; cmp_chan = 2;
    tick();
    chk(chain_flags[2] && !miss_flags[2], "R8 clear and set", 64'(miss_flags), 64'h80);
    idle_in(); sel_ready = 1;
    repeat (4) tick();

    // R9: both paths same channel
    cmp_valid = 1; cmp_chain = 1; cmp_chan = 4; early_valid = 1; early_chan = 4;
    tick();
    chk(chain_flags[4] && miss_flags[4], "R9 dual report", 64'(miss_flags), 64'h90);
    // R10: clear strobe, with a fresh miss on ch4 winning
    idle_in(); miss_clr = NCH'(1) << 7;
    tick();
    chk(!miss_flags[7] && miss_flags[4], "R10 w1c", 64'(miss_flags), 64'h10);
    miss_clr = NCH'(1) << 4; early_valid = 1; early_chan = 4;
    tick();
    chk(miss_flags[4], "R10 set wins", 64'(miss_flags), 64'h10);
    idle_in(); miss_clr = '1; sel_ready = 1;
    tick();
    chk(miss_flags == '0, "R10 clear all", 64'(miss_flags), 64'd0);

    // random traffic
    for (int k = 0; k < 3000; k++) begin
      cmp_valid   = ($urandom % 2) == 0;
      cmp_chain   = ($urandom % 3) != 0;
      cmp_chan    = CW'($urandom);
      early_valid = ($urandom % 4) == 0;
      early_chan  = CW'($urandom % 8);
      sel_ready   = ($urandom % 5) < 3;
      miss_clr    = (($urandom % 8) == 0) ? NCH'($urandom) : '0;
      if (($urandom % 16) == 0) begin
        evt_pend = NCH'($urandom);
        evt_en   = NCH'($urandom);
      end
      tick();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule